// File: doc/BRIEF.md
# Processor Bus Cycle Responder

This block is the system side of the local bus of a 16-bit x86-class processor. It produces the processor's power-up reset, watches the processor's status strobes to see what kind of bus cycle has begun, and ends each cycle with a one-clock ready pulse. Memory cycles are served from an internal word-wide RAM. Instruction fetches and data reads drive the stored word onto the data bus. Memory writes update only the byte lanes that the high-byte-enable and A0 pair selects.

I/O cycles, interrupt acknowledge cycles and halt/shutdown cycles are recognised and completed, but they do not touch memory. I/O and acknowledge reads return all ones. The RAM decodes only the low address bits, so every upper address range aliases onto the same words. Because of this, the reset vector region near the top of the 16 MB space lands on contents preloaded through a separate load port.

Top module: `bus_cycle_responder`

## Requirements
- R1: After `rst` is released, `cpu_reset_o` stays high for exactly RESET_CYCLES (default 16) more clock edges, then falls on a clock edge. While it is high, `ready_n_o` is 1 and `data_oe_o` is 0.
- R2: Status strobes that are sampled while `cpu_reset_o` is high start no cycle.
- R3: A cycle starts at a clock edge where the block is idle and `{s1_n_i,s0_n_i}` is not 2'b11. `ready_n_o` goes low after the second edge following that start edge and stays low for exactly one clock.
- R4: A read (`s1_n_i`=1, `s0_n_i`=0) with `m_io_i`=1 returns the stored word at index `addr_i[12:1]`. This holds both when `code_inta_i`=1 (instruction fetch) and when `code_inta_i`=0 (data read). The first fetch at 0xFFFFF0 therefore returns word 0xFF8.
- R5: On reads, bits 7:0 carry the even-address byte and bits 15:8 carry the odd-address byte. Lanes: `bhe_n_i`=0 with A0=0 selects the word, `bhe_n_i`=1 with A0=0 selects the low byte, and `bhe_n_i`=0 with A0=1 selects the high byte.
- R6: A memory write (`s1_n_i`=0, `s0_n_i`=1, `m_io_i`=1) stores `data_i` in the command phase. The low byte is written only when A0=0 and the high byte only when `bhe_n_i`=0. The other byte is kept, and with `bhe_n_i`=1 and A0=1 nothing changes.
- R7: `data_oe_o` is high only in the ready clock of a read-type cycle. It is never high during write or halt cycles.
- R8: With `m_io_i`=0, a read returns 0xFFFF with the output enable on. A write leaves memory unchanged.
- R9: Both strobes low with `code_inta_i`=0 and `m_io_i`=0 is an interrupt acknowledge, which returns 0xFFFF. Both strobes low with any other qualifier is a halt, which gets ready with the output enable off.
- R10: Address bits above bit 12 are ignored, so addresses that differ only there reach the same word.
- R11: Status strobes seen while a cycle is in progress do not start another cycle.
- R12: A load-port write (`load_we_i`=1) stores the full `load_data_i` word at `load_addr_i`, and that word is later readable by the processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high system reset |
| cpu_reset_o | output | 1 | Reset to the processor, active high, clock synchronous |
| ready_n_o | output | 1 | Cycle completion, active low |
| addr_i | input | 24 | Processor address bus |
| bhe_n_i | input | 1 | High byte enable, active low |
| code_inta_i | input | 1 | Code / interrupt-acknowledge qualifier |
| m_io_i | input | 1 | Memory (1) or I/O (0) qualifier |
| s1_n_i | input | 1 | Status strobe S1, active low |
| s0_n_i | input | 1 | Status strobe S0, active low |
| data_i | input | 16 | Data driven by the processor |
| data_o | output | 16 | Data returned to the processor |
| data_oe_o | output | 1 | Enable for `data_o` onto the bus |
| load_we_i | input | 1 | Load-port word write strobe |
| load_addr_i | input | 12 | Load-port word index |
| load_data_i | input | 16 | Load-port write data |

## Verification
The bench counts the high samples of `cpu_reset_o` while status strobes are held active. A generator that is one clock short, or a responder that reacts during reset, shows up there. Partial writes to a single word target each lane in turn and then the no-lane combination; a design with swapped lane enables would corrupt the untouched byte. The bench holds a status strobe across a whole cycle to catch a design that restarts while busy, and it reads aliased upper addresses to catch one that decodes too many address bits. Random cycle mixes compare against a bench memory model, so a wrong output-enable or data value on any cycle kind is reported.

// File: rtl/brsp_pkg.sv
package brsp_pkg;

  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_FETCH,
    CYC_MRD,
    CYC_MWR,
    CYC_IORD,
    CYC_IOWR,
    CYC_INTA,
    CYC_HALT
  } cyc_e;

  // Classify the bus cycle from the status strobes and qualifiers.
  function automatic cyc_e classify(input logic code_inta, input logic m_io,
                                    input logic s1_n, input logic s0_n);
    cyc_e c;
    case ({s1_n, s0_n})
      2'b11: c = CYC_NONE;
      2'b10: c = m_io ? (code_inta ? CYC_FETCH : CYC_MRD) : CYC_IORD;
      2'b01: c = m_io ? CYC_MWR : CYC_IOWR;
      default: c = (!code_inta && !m_io) ? CYC_INTA : CYC_HALT;
    endcase
    return c;
  endfunction

  function automatic logic drives_bus(input cyc_e c);
    return (c == CYC_FETCH) || (c == CYC_MRD) || (c == CYC_IORD) || (c == CYC_INTA);
  endfunction

  function automatic logic from_memory(input cyc_e c);
    return (c == CYC_FETCH) || (c == CYC_MRD);
  endfunction

endpackage

// File: rtl/brsp_reset_gen.sv
module brsp_reset_gen #(
  parameter int RESET_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  output logic cpu_rst_o
);
  localparam int CW = $clog2(RESET_CYCLES + 1) + 1;
  localparam logic [CW-1:0] LAST = CW'(RESET_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      cpu_rst_o <= 1'b1;
    end else begin
      cpu_rst_o <= (cnt != LAST);
      if (cnt != LAST) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/brsp_word_ram.sv
module brsp_word_ram #(
  parameter int AW    = 12,
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic [LANES-1:0]   we,
  input  logic [AW-1:0]      waddr,
  input  logic [8*LANES-1:0] wdata,
  input  logic [AW-1:0]      raddr,
  output logic [8*LANES-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [8*LANES-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we[l]) mem[waddr][l*8 +: 8] <= wdata[l*8 +: 8];
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/brsp_cycle_fsm.sv
module brsp_cycle_fsm
  import brsp_pkg::*;
#(
  parameter int MEM_AW = 12,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              code_inta,
  input  logic              m_io,
  input  logic              s1_n,
  input  logic              s0_n,
  input  logic [MEM_AW-1:0] word_idx,
  input  logic              a0,
  input  logic              bhe_n,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW-1:0]     rd_word,
  output logic [1:0]        ram_we,
  output logic [MEM_AW-1:0] ram_waddr,
  output logic [DW-1:0]     ram_wdata,
  output logic              ready_n,
  output logic              oe,
  output logic [DW-1:0]     data_o,
  output logic              idle
);
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_RESP} st_e;

  st_e               st;
  cyc_e              cyc_q;
  cyc_e              cyc_now;
  logic [MEM_AW-1:0] idx_q;
  logic [1:0]        lanes_q;

  assign cyc_now = classify(code_inta, m_io, s1_n, s0_n);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      st      <= ST_IDLE;
      cyc_q   <= CYC_NONE;
      idx_q   <= '0;
      lanes_q <= '0;
      ready_n <= 1'b1;
      oe      <= 1'b0;
      data_o  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (cyc_now != CYC_NONE) begin
            st      <= ST_CMD;
            cyc_q   <= cyc_now;
            idx_q   <= word_idx;
            lanes_q <= {~bhe_n, ~a0};
          end
        end
        ST_CMD: begin
          st      <= ST_RESP;
          ready_n <= 1'b0;
          oe      <= drives_bus(cyc_q);
          data_o  <= from_memory(cyc_q) ? rd_word : '1;
        end
        default: begin
          st      <= ST_IDLE;
          ready_n <= 1'b1;
          oe      <= 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    ram_we    = (st == ST_CMD && cyc_q == CYC_MWR && !hold) ? lanes_q : 2'b00;
    ram_waddr = idx_q;
    ram_wdata = wr_data;
    idle      = (st == ST_IDLE);
  end
endmodule

// File: rtl/bus_cycle_responder.sv
module bus_cycle_responder #(
  parameter int ADDR_W       = 24,
  parameter int MEM_AW       = 12,
  parameter int RESET_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cpu_reset_o,
  output logic              ready_n_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bhe_n_i,
  input  logic              code_inta_i,
  input  logic              m_io_i,
  input  logic              s1_n_i,
  input  logic              s0_n_i,
  input  logic [15:0]       data_i,
  output logic [15:0]       data_o,
  output logic              data_oe_o,
  input  logic              load_we_i,
  input  logic [MEM_AW-1:0] load_addr_i,
  input  logic [15:0]       load_data_i
);
  localparam int DW    = 16;
  localparam int LANES = DW / 8;

  logic              fsm_idle;
  logic [LANES-1:0]  bus_we;
  logic [MEM_AW-1:0] bus_waddr;
  logic [DW-1:0]     bus_wdata;
  logic [LANES-1:0]  ram_we;
  logic [MEM_AW-1:0] ram_waddr;
  logic [DW-1:0]     ram_wdata;
  logic [DW-1:0]     ram_rdata;
  logic              unused_high_addr;

  assign unused_high_addr = ^addr_i[ADDR_W-1:MEM_AW+1];

  brsp_reset_gen #(.RESET_CYCLES(RESET_CYCLES)) u_rst (
    .clk       (clk),
    .rst       (rst),
    .cpu_rst_o (cpu_reset_o)
  );

  brsp_cycle_fsm #(.MEM_AW(MEM_AW), .DW(DW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .hold      (cpu_reset_o),
    .code_inta (code_inta_i),
    .m_io      (m_io_i),
    .s1_n      (s1_n_i),
    .s0_n      (s0_n_i),
    .word_idx  (addr_i[MEM_AW:1]),
    .a0        (addr_i[0]),
    .bhe_n     (bhe_n_i),
    .wr_data   (data_i),
    .rd_word   (ram_rdata),
    .ram_we    (bus_we),
    .ram_waddr (bus_waddr),
    .ram_wdata (bus_wdata),
    .ready_n   (ready_n_o),
    .oe        (data_oe_o),
    .data_o    (data_o),
    .idle      (fsm_idle)
  );

  always_comb begin
    ram_we    = load_we_i ? {LANES{1'b1}} : bus_we;
    ram_waddr = load_we_i ? load_addr_i : bus_waddr;
    ram_wdata = load_we_i ? load_data_i : bus_wdata;
  end

  brsp_word_ram #(.AW(MEM_AW), .LANES(LANES)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (addr_i[MEM_AW:1]),
    .rdata (ram_rdata)
  );
endmodule

// File: rtl/brsp_checker.sv
module brsp_checker #(
  parameter int RESET_CYCLES = 16
) (
  input logic clk,
  input logic rst,
  input logic cpu_rst,
  input logic ready_n,
  input logic oe,
  input logic s1_n,
  input logic s0_n,
  input logic idle
);
  localparam int CW = $clog2(RESET_CYCLES + 2) + 1;

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (cpu_rst) begin
      if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
    end else hi_cnt <= '0;
  end

  // R1: reset pulse lasts at least the configured length
  a_r1_reset_length: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_rst) |-> (hi_cnt >= CW'(RESET_CYCLES)));

  // R1 / R2: no bus response while the processor is in reset
  a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
    cpu_rst |-> (ready_n && !oe));

  // R3: ready is a single-clock pulse
  a_r3_ready_single: assert property (@(posedge clk) disable iff (rst)
    !ready_n |=> ready_n);

  // R3: an accepted start yields ready two edges later
  a_r3_start_ready: assert property (@(posedge clk) disable iff (rst)
    (idle && !cpu_rst && !(s1_n && s0_n)) |=> ##1 !ready_n);

  // R7: output enable only inside the ready clock
  a_r7_oe_in_ready: assert property (@(posedge clk) disable iff (rst)
    oe |-> !ready_n);

  // R11: ready never coincides with the idle state
  a_r11_ready_busy: assert property (@(posedge clk) disable iff (rst)
    !ready_n |-> !idle);
endmodule

bind bus_cycle_responder brsp_checker #(.RESET_CYCLES(RESET_CYCLES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cpu_rst (cpu_reset_o),
  .ready_n (ready_n_o),
  .oe      (data_oe_o),
  .s1_n    (s1_n_i),
  .s0_n    (s0_n_i),
  .idle    (fsm_idle)
);

// File: tb/bus_cycle_responder_tb.sv
module bus_cycle_responder_tb;
  localparam int RST_LEN = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_reset, ready_n, oe;
  logic [23:0] addr;
  logic        bhe_n, code_inta, m_io, s1_n, s0_n;
  logic [15:0] wdata, rdata;
  logic        ld_we;
  logic [11:0] ld_addr;
  logic [15:0] ld_data;

  logic [15:0] model [4096];
  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  bus_cycle_responder u_dut (
    .clk(clk), .rst(rst), .cpu_reset_o(cpu_reset), .ready_n_o(ready_n),
    .addr_i(addr), .bhe_n_i(bhe_n), .code_inta_i(code_inta), .m_io_i(m_io),
    .s1_n_i(s1_n), .s0_n_i(s0_n), .data_i(wdata), .data_o(rdata),
    .data_oe_o(oe), .load_we_i(ld_we), .load_addr_i(ld_addr), .load_data_i(ld_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kinds: 0 fetch, 1 mem read, 2 mem write, 3 io read, 4 io write, 5 inta, 6 halt
  task automatic set_pins(input int kind);
    case (kind)
      0: begin code_inta = 1; m_io = 1; s1_n = 1; s0_n = 0; end
      1: begin code_inta = 0; m_io = 1; s1_n = 1; s0_n = 0; end
      2: begin code_inta = 0; m_io = 1; s1_n = 0; s0_n = 1; end
      3: begin code_inta = 0; m_io = 0; s1_n = 1; s0_n = 0; end
      4: begin code_inta = 0; m_io = 0; s1_n = 0; s0_n = 1; end
      5: begin code_inta = 0; m_io = 0; s1_n = 0; s0_n = 0; end
      default: begin code_inta = 1; m_io = 1; s1_n = 0; s0_n = 0; end
    endcase
  endtask

  function automatic logic [15:0] lane_mask(input logic bhen, input logic a0);
    return {(bhen ? 8'h00 : 8'hFF), (a0 ? 8'h00 : 8'hFF)};
  endfunction

  function automatic string tag_of(input int kind);
    case (kind)
      0, 1: return "R4/R5";
      2: return "R6/R7";
      3, 4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic do_cycle(input int kind, input logic [23:0] a, input logic bhen, input logic [15:0] wd);
    logic r1, o1;
    logic [15:0] d1, m, ed;
    logic eoe;
    string tg;
    tg = tag_of(kind);
    set_pins(kind); addr = a; bhe_n = bhen; wdata = 16'h0;
    @(posedge clk); @(negedge clk);
    chk(ready_n === 1'b1, "R3 early ready", {31'd0, ready_n}, 32'd1);
    s1_n = 1; s0_n = 1; wdata = wd;
    @(posedge clk); @(negedge clk);
    r1 = ready_n; o1 = oe; d1 = rdata;
    @(posedge clk); @(negedge clk);
    chk(r1 === 1'b0, "R3 ready pulse", {31'd0, r1}, 32'd0);
    chk(ready_n === 1'b1, "R3 ready released", {31'd0, ready_n}, 32'd1);
    chk(oe === 1'b0, "R7 oe released", {31'd0, oe}, 32'd0);
    eoe = (kind == 0 || kind == 1 || kind == 3 || kind == 5);
    chk(o1 === eoe, {tg, " oe"}, {31'd0, o1}, {31'd0, eoe});
    if (kind == 0 || kind == 1) begin
      m  = lane_mask(bhen, a[0]);
      ed = model[a[12:1]];
      chk((d1 & m) === (ed & m), {tg, " read data"}, {16'd0, d1 & m}, {16'd0, ed & m});
    end else if (kind == 3 || kind == 5) begin
      chk(d1 === 16'hFFFF, {tg, " all-ones read"}, {16'd0, d1}, 32'hFFFF);
    end
    if (kind == 2) begin
      if (!a[0]) model[a[12:1]][7:0]  = wd[7:0];
      if (!bhen) model[a[12:1]][15:8] = wd[15:8];
    end
  endtask

  task automatic read_word(input logic [23:0] a, input string req, input logic [15:0] exp);
    logic [15:0] got;
    set_pins(1); addr = a; bhe_n = 0;
    @(posedge clk); @(negedge clk);
    s1_n = 1; s0_n = 1;
    @(posedge clk); @(negedge clk);
    got = rdata;
    @(posedge clk); @(negedge clk);
    chk(got === exp, req, {16'd0, got}, {16'd0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    int hi_seen;
    seed = $urandom(32'h2860_5EED);
    rst = 1; ld_we = 0; ld_addr = 0; ld_data = 0;
    addr = 0; bhe_n = 1; code_inta = 0; m_io = 1; s1_n = 1; s0_n = 1; wdata = 0;
    @(negedge clk);
    // R12: preload every word through the load port
    for (int i = 0; i < 4096; i++) begin
      ld_we = 1; ld_addr = 12'(i); ld_data = 16'($urandom);
      model[i] = ld_data;
      @(negedge clk);
    end
    ld_we = 0;
    chk(cpu_reset === 1'b1, "R1 reset held", {31'd0, cpu_reset}, 32'd1);
    chk(ready_n === 1'b1 && oe === 1'b0, "R1 idle outputs", {30'd0, ready_n, oe}, 32'd2);
    // R2: keep a read strobe active while the processor is in reset
    set_pins(0); addr = 24'hFFFFF0; bhe_n = 0;
    rst = 0;
    hi_seen = 0;
    for (int n = 0; n < 40; n++) begin
      @(posedge clk); @(negedge clk);
      if (cpu_reset !== 1'b1) break;
      hi_seen++;
      chk(ready_n === 1'b1 && oe === 1'b0, "R2 no response in reset", {30'd0, ready_n, oe}, 32'd2);
    end
    chk(hi_seen == RST_LEN, "R1 reset length", hi_seen, RST_LEN);
    s1_n = 1; s0_n = 1;
    @(posedge clk); @(negedge clk);
    chk(ready_n === 1'b1, "R2 strobe during reset ignored", {31'd0, ready_n}, 32'd1);
    // R4: first fetch at the reset vector
    read_word(24'hFFFFF0, "R4 reset vector fetch", model[12'hFF8]);
    do_cycle(0, 24'hFFFFF0, 1'b0, 16'h0);
    // R6: lane-selective writes
    do_cycle(2, 24'h000100, 1'b0, 16'h1234);
    read_word(24'h000100, "R6 word write", 16'h1234);
    do_cycle(2, 24'h000101, 1'b0, 16'hAB00);
    read_word(24'h000100, "R6 high byte write", 16'hAB34);
    do_cycle(2, 24'h000100, 1'b1, 16'h00CD);
    read_word(24'h000100, "R6 low byte write", 16'hABCD);
    do_cycle(2, 24'h000101, 1'b1, 16'h5555);
    read_word(24'h000100, "R6 no-lane write", 16'hABCD);
    // R5: byte reads on each lane
    do_cycle(1, 24'h000100, 1'b1, 16'h0);
    do_cycle(1, 24'h000101, 1'b0, 16'h0);
    // R10: aliased upper address bits
    read_word(24'hF00100, "R10 alias", 16'hABCD);
    read_word(24'h5A2100, "R10 alias", 16'hABCD);
    // R8: I/O cycles leave memory alone
    do_cycle(4, 24'h000100, 1'b0, 16'h9999);
    read_word(24'h000100, "R8 io write ignored", 16'hABCD);
    do_cycle(3, 24'h000100, 1'b0, 16'h0);
    // R9: acknowledge and halt
    do_cycle(5, 24'h000000, 1'b0, 16'h0);
    do_cycle(6, 24'h000002, 1'b0, 16'h0);
    // R11: strobe held over the whole cycle
    set_pins(1); addr = 24'h000100; bhe_n = 0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk(ready_n === 1'b0, "R11 ready with held strobe", {31'd0, ready_n}, 32'd0);
    @(posedge clk); @(negedge clk);
    s1_n = 1; s0_n = 1;
    chk(ready_n === 1'b1, "R11 ready released", {31'd0, ready_n}, 32'd1);
    @(posedge clk); @(negedge clk);
    chk(ready_n === 1'b1, "R11 no restart", {31'd0, ready_n}, 32'd1);
    @(posedge clk); @(negedge clk);
    chk(ready_n === 1'b1, "R11 no restart", {31'd0, ready_n}, 32'd1);
    // random mix
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [23:0] a;
      logic bh;
      k  = $urandom_range(0, 6);
      a  = 24'($urandom);
      if ($urandom_range(0, 1) == 1) a[12:0] = {8'h02, 5'($urandom)};
      bh = 1'($urandom);
      do_cycle(k, a, bh, 16'($urandom));
      if ($urandom_range(0, 3) == 0) begin
        @(posedge clk); @(negedge clk);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule